// File: doc/BRIEF.md
# PMBus Slave Byte Receiver with Selectable Acknowledge

This block is the byte-level receive engine of an SMBus/PMBus slave. It sits behind a bit-level I2C front end. That front end reports bus START and STOP as single-cycle strobes and hands over each received byte on a valid/ready stream. The engine tracks the address phase, the following data bytes and the closing STOP. It raises an interrupt for each of these with an event code that software can read, and it latches every byte it reports into a read-only data register.

An acknowledge bit is produced for every byte without waiting for software. Its value comes from a source that software picks before the byte arrives. The source can be a forced NACK, a 128-entry address bitmap, a 256-entry byte mask bitmap, or a comparison against the CRC-8 packet error code computed over the transaction so far. After each reported byte the engine holds the stream by keeping ready low, which stretches the bus clock, until software pulses a trigger. If the byte was refused, that trigger sends the engine into a drop state that discards everything until STOP.

Back-pressure rules on the byte stream: a byte moves when `rx_valid` and `rx_ready` are both high on a rising clock edge. The front end must hold `rx_byte` stable while `rx_valid` is high and `rx_ready` is low. `rx_ready` is low only while a reported byte waits for the software trigger. The acknowledge for a moved byte appears as a one-cycle `ack_valid` pulse on the next cycle.

Top module: `pmb_rx_engine`

## Requirements
- R1: A START strobe raises the interrupt with event code 0. It also clears the PEC accumulator to 0x00 and puts the engine in the address phase, even when the engine is in the middle of a byte or a hold.
- R2: In the address phase, a byte with bit 0 = 0 (write) raises event code 1, is latched into `rx_data` and is acknowledged from the selected source. A byte with bit 0 = 1 (read) is NACKed, raises no event and puts the engine in the drop state.
- R3: In the data phase, every received byte raises event code 2 and is latched into `rx_data` on the same clock edge that sets the interrupt.
- R4: A STOP strobe in any state raises event code 3 and returns the engine to idle. If START and STOP arrive in the same cycle, START wins. A bus strobe discards a byte that moves in the same cycle.
- R5: After a reported byte (write address or data), `rx_ready` stays low until a cycle with `rx_trig` high. A trigger has no effect in any other state.
- R6: Acknowledge source 0 (`ack_sel` = 0) always gives NACK.
- R7: Acknowledge source 1 gives the address bitmap bit indexed by `rx_byte[7:1]`.
- R8: Acknowledge source 2 gives the mask bitmap bit indexed by the full byte value. A set bit means ACK. Bitmaps are written through `map_we`: `map_sel` = 0 writes the address bitmap at `map_idx[6:0]`, and `map_sel` = 1 writes the mask bitmap at `map_idx`.
- R9: Acknowledge source 3 ACKs a byte only if it equals the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) of all earlier bytes since the last START, the address byte included.
- R10: One cycle after a byte moves, `ack_valid` pulses for one cycle with `ack_bit` set to the generated value. `ack_status` keeps the value generated for the most recent byte.
- R11: A trigger while the last generated acknowledge is NACK enters the drop state. In that state, bytes are accepted and NACKed, raise no event and leave `rx_data` unchanged until STOP or START.
- R12: `irq_clr` clears the interrupt (write-one-to-clear). If a new event arrives in the same cycle, the interrupt stays set and the code takes the new value.
- R13: In idle (before any START), bytes are accepted and NACKed and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START or repeated START strobe from front end |
| ev_stop | input | 1 | STOP strobe from front end |
| rx_valid | input | 1 | Received byte available |
| rx_byte | input | 8 | Received byte value |
| rx_ready | output | 1 | Engine can take a byte (low = clock stretch) |
| ack_valid | output | 1 | One-cycle pulse: acknowledge decision ready |
| ack_bit | output | 1 | Acknowledge to drive (1 = ACK) |
| ack_sel | input | 2 | Acknowledge source: 0 NACK, 1 address map, 2 mask map, 3 PEC |
| rx_trig | input | 1 | Software trigger to leave the hold state |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| map_we | input | 1 | Bitmap write enable |
| map_sel | input | 1 | Bitmap select: 0 address, 1 mask |
| map_idx | input | 8 | Bitmap entry index |
| map_val | input | 1 | Bitmap entry value |
| irq | output | 1 | Interrupt flag |
| irq_code | output | 2 | Event code: 0 START, 1 write address, 2 data byte, 3 STOP |
| ack_status | output | 1 | Acknowledge generated for the latest byte |
| rx_data | output | 8 | Latest reported byte |

## Verification
Every result is registered once. `irq`, `irq_code`, `rx_data`, `ack_valid`, `ack_bit` and `ack_status` change on the first rising edge that samples the strobe, moved byte or trigger. `rx_ready` drops after the edge that takes a reported byte and rises after the edge that samples the trigger. The bench drives inputs on falling edges and keeps a behavioural model that steps on the same rising edge. It compares every output on the next falling edge, so each result is checked exactly one edge after its cause. The directed checks inside each scenario also read the outputs at that falling edge.

// File: rtl/pmb_rx_pkg.sv
`timescale 1ns/1ps
package pmb_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_DATA = 3'd3,
    ST_DROP = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    EV_START   = 2'd0,
    EV_ADDR_WR = 2'd1,
    EV_BYTE    = 2'd2,
    EV_STOP    = 2'd3
  } ev_code_e;

  typedef enum logic [1:0] {
    SRC_NACK     = 2'd0,
    SRC_ADDR_MAP = 2'd1,
    SRC_MASK_MAP = 2'd2,
    SRC_PEC      = 2'd3
  } ack_src_e;

endpackage

// File: rtl/pmb_rx_crc.sv
`timescale 1ns/1ps
module pmb_rx_crc #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q, crc_d;

  // bit-serial division unrolled over one byte, MSB first
  always_comb begin
    crc_d = crc_q;
    for (int i = W - 1; i >= 0; i--) begin
      if (crc_d[W-1] ^ din[i]) crc_d = {crc_d[W-2:0], 1'b0} ^ POLY;
      else                     crc_d = {crc_d[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (upd) crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R1
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));

  // R9
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(crc));

endmodule

// File: rtl/pmb_rx_ack_src.sv
`timescale 1ns/1ps
module pmb_rx_ack_src
  import pmb_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         map_we,
  input  logic         map_sel,
  input  logic [W-1:0] map_idx,
  input  logic         map_val,
  input  ack_src_e     src,
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] crc_in,
  output logic         ack
);
  localparam int ABITS  = W - 1;
  localparam int ADDR_N = 1 << ABITS;
  localparam int MASK_N = 1 << W;

  logic [ADDR_N-1:0] addr_map;
  logic [MASK_N-1:0] mask_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_map <= '0;
      mask_map <= '0;
    end else if (map_we) begin
      if (map_sel) mask_map[map_idx] <= map_val;
      else         addr_map[map_idx[ABITS-1:0]] <= map_val;
    end
  end

  always_comb begin
    unique case (src)
      SRC_NACK:     ack = 1'b0;
      SRC_ADDR_MAP: ack = addr_map[byte_in[W-1:1]];
      SRC_MASK_MAP: ack = mask_map[byte_in];
      SRC_PEC:      ack = (byte_in == crc_in);
      default:      ack = 1'b0;
    endcase
  end

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && map_sel && map_val) |=>
      (((src == SRC_MASK_MAP) && (byte_in == $past(map_idx))) -> ack));

endmodule

// File: rtl/pmb_rx_irq.sv
`timescale 1ns/1ps
module pmb_rx_irq
  import pmb_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set,
  input  ev_code_e code_in,
  input  logic     clr,
  output logic     irq,
  output ev_code_e code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      code <= EV_START;
    end else if (set) begin
      irq  <= 1'b1;
      code <= code_in;
    end else if (clr) begin
      irq  <= 1'b0;
    end
  end

  // R12
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (irq && (code == $past(code_in))));

  // R12
  irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);

endmodule

// File: rtl/pmb_rx_fsm.sv
`timescale 1ns/1ps
module pmb_rx_fsm
  import pmb_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_trig,
  input  logic         ack_now,
  output logic         rx_ready,
  output logic         ack_valid,
  output logic         ack_bit,
  output logic         ack_status,
  output logic [W-1:0] rx_data,
  output logic         crc_clr,
  output logic         crc_upd,
  output logic         ev_set,
  output ev_code_e     ev_code
);
  rx_state_e st, st_nx;
  logic byte_acc, wr_addr, in_data, take, ack_gen;

  assign rx_ready = (st != ST_HOLD);
  assign byte_acc = rx_valid && rx_ready && !ev_start && !ev_stop;
  assign wr_addr  = (st == ST_ADDR) && !rx_byte[0];
  assign in_data  = (st == ST_DATA);
  assign take     = byte_acc && (wr_addr || in_data);
  assign ack_gen  = take && ack_now;
  assign crc_clr  = ev_start;
  assign crc_upd  = byte_acc && ((st == ST_ADDR) || in_data);

  always_comb begin
    ev_set  = 1'b1;
    ev_code = EV_START;
    if (ev_start)     ev_code = EV_START;
    else if (ev_stop) ev_code = EV_STOP;
    else if (take)    ev_code = wr_addr ? EV_ADDR_WR : EV_BYTE;
    else              ev_set  = 1'b0;
  end

  always_comb begin
    st_nx = st;
    if (ev_start)     st_nx = ST_ADDR;
    else if (ev_stop) st_nx = ST_IDLE;
    else begin
      unique case (st)
        ST_ADDR: if (byte_acc) st_nx = wr_addr ? ST_HOLD : ST_DROP;
        ST_DATA: if (byte_acc) st_nx = ST_HOLD;
        ST_HOLD: if (rx_trig)  st_nx = ack_status ? ST_DATA : ST_DROP;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ack_valid  <= 1'b0;
      ack_bit    <= 1'b0;
      ack_status <= 1'b0;
      rx_data    <= '0;
    end else begin
      st        <= st_nx;
      ack_valid <= byte_acc;
      if (byte_acc) begin
        ack_bit    <= ack_gen;
        ack_status <= ack_gen;
      end
      if (take) rx_data <= rx_byte;
    end
  end

  // R5
  stall_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !rx_ready);

  // R5
  trig_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_HOLD) && rx_trig && !ev_start && !ev_stop) |=> rx_ready);

  // R11
  drop_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DROP) && byte_acc) |=> (ack_valid && !ack_bit));

  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start) |=> (st == ST_IDLE));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |=> ack_valid);

  // R10
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_acc |=> !ack_valid);

endmodule

// File: rtl/pmb_rx_engine.sv
`timescale 1ns/1ps
module pmb_rx_engine
  import pmb_rx_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         rx_ready,
  output logic         ack_valid,
  output logic         ack_bit,
  input  logic [1:0]   ack_sel,
  input  logic         rx_trig,
  input  logic         irq_clr,
  input  logic         map_we,
  input  logic         map_sel,
  input  logic [W-1:0] map_idx,
  input  logic         map_val,
  output logic         irq,
  output logic [1:0]   irq_code,
  output logic         ack_status,
  output logic [W-1:0] rx_data
);
  logic         crc_clr, crc_upd, ev_set, ack_now;
  logic [W-1:0] crc_val;
  ev_code_e     ev_code, code_q;

  pmb_rx_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_trig(rx_trig), .ack_now(ack_now),
    .rx_ready(rx_ready), .ack_valid(ack_valid), .ack_bit(ack_bit),
    .ack_status(ack_status), .rx_data(rx_data), .crc_clr(crc_clr),
    .crc_upd(crc_upd), .ev_set(ev_set), .ev_code(ev_code)
  );

  pmb_rx_crc #(.W(W), .POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .din(rx_byte), .crc(crc_val)
  );

  pmb_rx_ack_src #(.W(W)) u_ack (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_sel(map_sel),
    .map_idx(map_idx), .map_val(map_val), .src(ack_src_e'(ack_sel)),
    .byte_in(rx_byte), .crc_in(crc_val), .ack(ack_now)
  );

  pmb_rx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .code_in(ev_code),
    .clr(irq_clr), .irq(irq), .code(code_q)
  );

  assign irq_code = code_q;

  // R6
  forced_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !ev_start && !ev_stop && (ack_sel == 2'd0)) |=> !ack_bit);

  // R4
  stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start) |=> (irq && (irq_code == 2'd3)));

endmodule

// File: tb/pmb_rx_engine_tb.sv
`timescale 1ns/1ps
module pmb_rx_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, rx_valid = 0, rx_trig = 0, irq_clr = 0;
  logic map_we = 0, map_sel = 0, map_val = 0;
  logic [7:0] rx_byte = 0, map_idx = 0;
  logic [1:0] ack_sel = 0;
  logic rx_ready, ack_valid, ack_bit, irq, ack_status;
  logic [1:0] irq_code;
  logic [7:0] rx_data;

  int total = 0, bad = 0;
  bit started = 0, done = 0;

  localparam int M_IDLE = 0, M_ADDR = 1, M_HOLD = 2, M_DATA = 3, M_DROP = 4;
  int m_st = M_IDLE, m_code = 0;
  bit m_irq = 0, m_ack_valid = 0, m_ack_bit = 0, m_ack_status = 0, m_took = 0;
  logic [7:0] m_data = 0;
  bit alut [128];
  bit dlut [256];
  logic [7:0] hist [$];

  always #2.5 clk = ~clk;

  pmb_rx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .ack_valid(ack_valid), .ack_bit(ack_bit), .ack_sel(ack_sel),
    .rx_trig(rx_trig), .irq_clr(irq_clr), .map_we(map_we), .map_sel(map_sel),
    .map_idx(map_idx), .map_val(map_val), .irq(irq), .irq_code(irq_code),
    .ack_status(ack_status), .rx_data(rx_data)
  );

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    int r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = (r & 8'h80) ? (((r << 1) ^ 8'h07) & 8'hff) : ((r << 1) & 8'hff);
    return r[7:0];
  endfunction

  function automatic bit src_ack(input int sel, input logic [7:0] b);
    logic [7:0] c;
    c = 8'h00;
    foreach (hist[i]) c = crc_step(c, hist[i]);
    case (sel)
      1: return alut[b >> 1];
      2: return dlut[b];
      3: return b == c;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    bit acc, a, ev;
    if (!rst_n) begin
      m_st = M_IDLE; m_irq = 0; m_code = 0; m_ack_valid = 0; m_ack_bit = 0;
      m_ack_status = 0; m_data = 0; m_took = 0; hist.delete();
      foreach (alut[i]) alut[i] = 0;
      foreach (dlut[i]) dlut[i] = 0;
    end else begin
      acc = rx_valid && (m_st != M_HOLD);
      m_took = acc;
      m_ack_valid = 0;
      ev = 0;
      if (ev_start) begin
        m_st = M_ADDR; hist.delete(); ev = 1; m_code = 0;
      end else if (ev_stop) begin
        m_st = M_IDLE; ev = 1; m_code = 3;
      end else if (acc) begin
        m_ack_valid = 1; a = 0;
        if (m_st == M_ADDR && rx_byte[0] == 1'b0) begin
          a = src_ack(ack_sel, rx_byte); ev = 1; m_code = 1; m_data = rx_byte;
          hist.push_back(rx_byte); m_st = M_HOLD;
        end else if (m_st == M_ADDR) begin
          hist.push_back(rx_byte); m_st = M_DROP;
        end else if (m_st == M_DATA) begin
          a = src_ack(ack_sel, rx_byte); ev = 1; m_code = 2; m_data = rx_byte;
          hist.push_back(rx_byte); m_st = M_HOLD;
        end
        m_ack_bit = a; m_ack_status = a;
      end else if (m_st == M_HOLD && rx_trig) begin
        m_st = m_ack_status ? M_DATA : M_DROP;
      end
      if (ev) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (map_we) begin
        if (map_sel) dlut[map_idx] = map_val;
        else alut[map_idx[6:0]] = map_val;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5 rx_ready", rx_ready, m_st != M_HOLD);
      chk("R12 irq", irq, m_irq);
      chk("R1 irq_code", irq_code, m_code);
      chk("R10 ack_valid", ack_valid, m_ack_valid);
      chk("R10 ack_bit", ack_bit, m_ack_bit);
      chk("R10 ack_status", ack_status, m_ack_status);
      chk("R3 rx_data", rx_data, m_data);
    end
  end

  task automatic do_start(); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic do_stop();  ev_stop = 1;  @(negedge clk); ev_stop = 0;  endtask
  task automatic do_trig();  rx_trig = 1;  @(negedge clk); rx_trig = 0;  endtask
  task automatic do_clr();   irq_clr = 1;  @(negedge clk); irq_clr = 0;  endtask
  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1;
    do @(negedge clk); while (!m_took);
    rx_valid = 0;
  endtask
  task automatic wr_map(input logic s, input logic [7:0] i, input logic v);
    map_we = 1; map_sel = s; map_idx = i; map_val = v;
    @(negedge clk); map_we = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset rx_ready", rx_ready, 1);
    chk("R12 reset irq", irq, 0);
    chk("R10 reset ack_valid", ack_valid, 0);
    rst_n = 1; started = 1;
    wr_map(0, 8'h40, 1); wr_map(1, 8'h21, 1); wr_map(1, 8'h55, 1);

    // full write with PEC, then forced NACK and drop
    do_start();
    chk("R1 start irq", irq, 1); chk("R1 start code", irq_code, 0);
    do_clr(); chk("R12 w1c", irq, 0);
    ack_sel = 1; send(8'h80);
    chk("R7 addr ack", ack_bit, 1); chk("R2 addr code", irq_code, 1);
    chk("R2 addr data", rx_data, 8'h80); chk("R5 stall", rx_ready, 0);
    repeat (3) @(negedge clk); chk("R5 still stalled", rx_ready, 0);
    do_clr(); do_trig(); chk("R5 released", rx_ready, 1);
    ack_sel = 2; send(8'h21);
    chk("R8 mask ack", ack_bit, 1); chk("R3 data code", irq_code, 2); chk("R3 data latch", rx_data, 8'h21);
    do_trig(); send(8'h55); chk("R8 mask ack2", ack_bit, 1);
    ack_sel = 3; do_trig();
    send(crc_step(crc_step(crc_step(8'h00, 8'h80), 8'h21), 8'h55));
    chk("R9 pec match", ack_bit, 1);
    ack_sel = 0; do_trig(); send(8'h12);
    chk("R6 forced nack", ack_bit, 0); chk("R10 status", ack_status, 0);
    do_clr(); do_trig(); send(8'h33);
    chk("R11 drop nack", ack_bit, 0); chk("R11 drop no irq", irq, 0); chk("R11 drop data", rx_data, 8'h12);
    do_stop(); chk("R4 stop code", irq_code, 3); chk("R4 stop ready", rx_ready, 1);

    // wrong PEC
    do_start(); ack_sel = 1; send(8'h80); do_trig();
    ack_sel = 3; send(crc_step(8'h00, 8'h80) ^ 8'h01);
    chk("R9 pec mismatch", ack_bit, 0); do_trig(); do_stop();

    // unknown address
    do_start(); ack_sel = 1; send(8'h82);
    chk("R7 addr miss", ack_bit, 0); chk("R2 miss code", irq_code, 1);
    do_trig(); do_clr(); send(8'h40);
    chk("R11 drop after nack", ack_bit, 0); chk("R11 no event", irq, 0); do_stop();

    // read address
    do_start(); do_clr(); send(8'h81);
    chk("R2 read nack", ack_bit, 0); chk("R2 read no irq", irq, 0); chk("R2 read no stall", rx_ready, 1);
    do_stop();

    // idle bytes and idle trigger
    do_clr(); send(8'h44);
    chk("R13 idle nack", ack_bit, 0); chk("R13 idle no irq", irq, 0); chk("R13 idle data", rx_data, 8'h82);
    do_trig(); chk("R5 trig ignored", rx_ready, 1); chk("R5 status kept", ack_status, 0);

    // clear collides with event
    do_start(); do_clr(); do_stop();
    ev_start = 1; irq_clr = 1; @(negedge clk); ev_start = 0; irq_clr = 0;
    chk("R12 event wins", irq, 1); chk("R12 event code", irq_code, 0);

    // repeated START during hold resets PEC
    ack_sel = 1; send(8'h80); do_start();
    chk("R4 restart ready", rx_ready, 1); chk("R1 restart code", irq_code, 0);
    send(8'h80); do_trig(); ack_sel = 3; send(crc_step(8'h00, 8'h80));
    chk("R1 pec restarted", ack_bit, 1); do_trig(); do_stop();

    // mask miss
    do_start(); ack_sel = 1; send(8'h80); do_trig(); ack_sel = 2; send(8'h22);
    chk("R8 mask miss", ack_bit, 0); do_trig(); do_stop();

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule